// File: doc/BRIEF.md
# Interrupt Holdoff Rate Limiter

This block sits between a device event line and a processor interrupt request. When the system is idle, an event raises the request on the next clock. The request then stays high until the service routine dismisses it. Dismissal starts a holdoff window whose length comes from a run-time count input. During that window the request stays low. Events that arrive inside the window are remembered in one sticky flag. When the window ends, they are presented as a single request. This caps the interrupt rate under bursty traffic, so one service call handles many events. The window opens only on dismissal, so a lone event after a quiet spell is never delayed.

The holdoff count is sampled only at the dismissal edge. A count of zero still forces a single low cycle after each dismissal. Beyond that, it turns the block into a plain pending latch.

Top module: `irq_holdoff_gate`

## Requirements
- R1: While reset is asserted and on the first clock after reset, `irq_o` is low and no holdoff window is running.
- R2: With no request high and no window running, an `evt_i` high at a clock edge makes `irq_o` high right after that same edge.
- R3: Once high, `irq_o` stays high on every edge where `dismiss_i` is low. Events seen while it is high are absorbed and create no later extra request.
- R4: A `dismiss_i` high at edge E0 while `irq_o` is high drives `irq_o` low after E0 and captures N = `holdoff_i`. `irq_o` stays low after edges E1 through EN and may rise no earlier than after edge E(N+1).
- R5: Any number of `evt_i` pulses sampled from E0 through E(N+1) yield exactly one rise of `irq_o`, right after E(N+1).
- R6: If no event is sampled from E0 through E(N+1), `irq_o` stays low after E(N+1) and the block is idle again, so a later event is signalled per R2.
- R7: `dismiss_i` while `irq_o` is low is ignored: it neither starts nor restarts a window and does not change the rise time of any request.
- R8: With N = 0, `irq_o` is low for exactly one cycle after a dismissal. It rises after E1 if an event was sampled at E0 or E1.
- R9: Changing `holdoff_i` while a window runs does not alter that window. The new value applies from the next dismissal.
- R10: The holdoff count is a 16-bit unsigned value, so windows of several hundred cycles and more are honoured exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | Device event, sampled every edge |
| dismiss_i | input | 1 | Handler dismissal strobe |
| holdoff_i | input | 16 | Holdoff length in cycles, captured at dismissal |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A corrupted timer shows up at `irq_o` as a rise that comes one or more edges too early or too late relative to E(N+1). This is detectable on the first burst after any dismissal. A lost or stuck pending flag shows up in one of two ways: a burst that never produces its request, or a phantom request after a quiet window. Either appears within N+2 cycles of the dismissal. Wrong idle detection adds a cycle or more of latency to the first event after a quiet spell, and that is visible on the very next event.

// File: rtl/evt_gate_pkg.sv
package evt_gate_pkg;

  typedef enum logic [1:0] {
    GS_IDLE   = 2'd0,
    GS_RAISED = 2'd1,
    GS_HOLD   = 2'd2
  } gate_state_t;

  // Down-count step that never wraps below zero
  function automatic logic [15:0] cnt_step(input logic [15:0] cur);
    return (cur == 16'd0) ? 16'd0 : cur - 16'd1;
  endfunction

  // Decision at the end of a holdoff window
  function automatic gate_state_t window_exit(input logic pend, input logic evt);
    return (pend || evt) ? GS_RAISED : GS_IDLE;
  endfunction

endpackage

// File: rtl/holdoff_timer.sv
module holdoff_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pend_latch.sv
module pend_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (clr) begin
      pend <= 1'b0;
    end else if (set) begin
      pend <= 1'b1;
    end
  end
endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
  import evt_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic dismiss,
  input  logic pend,
  input  logic tmr_zero,
  output logic raised,
  output logic holding
);
  gate_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      GS_IDLE:   if (evt) st_d = GS_RAISED;
      GS_RAISED: if (dismiss) st_d = GS_HOLD;
      GS_HOLD:   if (tmr_zero) st_d = window_exit(pend, evt);
      default:   st_d = GS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= GS_IDLE;
    else        st_q <= st_d;
  end

  assign raised  = (st_q == GS_RAISED);
  assign holding = (st_q == GS_HOLD);
endmodule

// File: rtl/irq_holdoff_gate.sv
module irq_holdoff_gate #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             dismiss_i,
  input  logic [CNT_W-1:0] holdoff_i,
  output logic             irq_o
);
  // Named internal events, brought out for the checker
  logic raised, holding, tmr_zero, pend_q;
  logic dismiss_hit;   // accepted dismissal
  logic window_end;    // holdoff window expires this edge
  logic pend_set;

  assign dismiss_hit = raised && dismiss_i;
  assign window_end  = holding && tmr_zero;
  assign pend_set    = evt_i && (holding || dismiss_hit);

  holdoff_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dismiss_hit),
    .load_val (holdoff_i),
    .dec      (holding),
    .zero     (tmr_zero)
  );

  pend_latch u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (pend_set),
    .clr   (window_end),
    .pend  (pend_q)
  );

  gate_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_i),
    .dismiss  (dismiss_i),
    .pend     (pend_q),
    .tmr_zero (tmr_zero),
    .raised   (raised),
    .holding  (holding)
  );

  assign irq_o = raised;
endmodule

// File: rtl/irq_holdoff_gate_chk.sv
module irq_holdoff_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic evt_i,
  input logic dismiss_i,
  input logic irq_o,
  input logic holding,
  input logic tmr_zero,
  input logic pend_q
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !irq_o); // R1
  AST_IDLE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !holding && evt_i) |=> irq_o); // R2
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !dismiss_i) |=> irq_o); // R3
  AST_DISMISS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && dismiss_i) |=> (!irq_o && holding)); // R4
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && !tmr_zero) |=> (!irq_o && holding)); // R4
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && !tmr_zero && pend_q) |=> pend_q); // R5
  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && tmr_zero && (pend_q || evt_i)) |=> irq_o); // R5
  AST_QUIET_END: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && tmr_zero && !pend_q && !evt_i) |=> (!irq_o && !holding)); // R6
  AST_IDLE_DISMISS: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !holding && dismiss_i && !evt_i) |=> (!irq_o && !holding)); // R7
endmodule

bind irq_holdoff_gate irq_holdoff_gate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_i     (evt_i),
  .dismiss_i (dismiss_i),
  .irq_o     (irq_o),
  .holding   (holding),
  .tmr_zero  (tmr_zero),
  .pend_q    (pend_q)
);

// File: tb/test_irq_holdoff_gate.sv
module test_irq_holdoff_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_i = 1'b0;
  logic        dismiss_i = 1'b0;
  logic [15:0] holdoff_i = 16'd0;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_holdoff_gate i_irq_holdoff_gate (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .dismiss_i(dismiss_i),
    .holdoff_i(holdoff_i), .irq_o(irq_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: irq_o=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  // Raise a request from idle: event sampled at the next edge
  task automatic raise_from_idle(input string req);
    evt_i = 1'b1;
    tick();
    evt_i = 1'b0;
    check(req, irq_o, 1'b1);
  endtask

  // Dismiss with window n; events on the listed offsets (bit k = edge Ek)
  // Returns with irq_o state checked after E(n+1)
  task automatic window(input string req, input int n, input logic [63:0] evmask,
                        input logic exp_end);
    holdoff_i = n[15:0];
    dismiss_i = 1'b1;
    evt_i = evmask[0];
    tick();                       // E0
    dismiss_i = 1'b0;
    check("R4", irq_o, 1'b0);
    for (int k = 1; k <= n; k++) begin
      evt_i = (k < 64) ? evmask[k] : 1'b0;
      tick();
      if (irq_o !== 1'b0) check("R4", irq_o, 1'b0);
      else n_chk++;
    end
    evt_i = (n + 1 < 64) ? evmask[n+1] : 1'b0;
    tick();                       // E(n+1)
    evt_i = 1'b0;
    check(req, irq_o, exp_end);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #1 check("R1", irq_o, 1'b0);
    repeat (3) tick();
    check("R1", irq_o, 1'b0);
    rst_n = 1'b1;
    tick();
    check("R1", irq_o, 1'b0);
  endtask

  task automatic t_idle_and_held();
    raise_from_idle("R2");
    evt_i = 1'b1;
    repeat (5) tick();
    evt_i = 1'b0;
    check("R3", irq_o, 1'b1);
    // events while high absorbed: quiet window ends low
    window("R3", 3, 64'h0, 1'b0);
  endtask

  task automatic t_coalesce();
    raise_from_idle("R2");
    window("R5", 6, 64'b0010_1010, 1'b1);
    // one request only: held, then quiet window returns idle
    tick();
    check("R5", irq_o, 1'b1);
    window("R6", 4, 64'h0, 1'b0);
    tick();
    check("R6", irq_o, 1'b0);
    raise_from_idle("R6");
  endtask

  task automatic t_late_event();
    // event on the very last edge of the window, and at dismissal edge
    window("R5", 5, 64'b100_0000, 1'b1);
    window("R5", 5, 64'b1, 1'b1);
  endtask

  task automatic t_ignored_dismiss();
    window("R6", 2, 64'h0, 1'b0);
    dismiss_i = 1'b1;
    tick();
    dismiss_i = 1'b0;
    check("R7", irq_o, 1'b0);
    raise_from_idle("R7");
    // dismissal strobes inside a window do not restart it
    holdoff_i = 16'd10;
    dismiss_i = 1'b1;
    tick();
    dismiss_i = 1'b0;
    repeat (4) tick();
    evt_i = 1'b1; dismiss_i = 1'b1;
    tick();
    evt_i = 1'b0; dismiss_i = 1'b0;
    repeat (5) tick();            // now after E10
    check("R7", irq_o, 1'b0);
    tick();                       // E11
    check("R7", irq_o, 1'b1);
  endtask

  task automatic t_zero();
    window("R8", 0, 64'h0, 1'b0);
    raise_from_idle("R8");
    window("R8", 0, 64'b1, 1'b1);
    window("R8", 0, 64'b10, 1'b1);
  endtask

  task automatic t_change_mid();
    holdoff_i = 16'd8;
    dismiss_i = 1'b1;
    evt_i = 1'b1;
    tick();
    dismiss_i = 1'b0;
    evt_i = 1'b0;
    holdoff_i = 16'd2;
    repeat (8) tick();            // after E8
    check("R9", irq_o, 1'b0);
    tick();                       // E9
    check("R9", irq_o, 1'b1);
    window("R9", 2, 64'b1, 1'b1); // new value used next time
  endtask

  task automatic t_long();
    window("R10", 700, 64'h10, 1'b1);
  endtask

  initial begin
    t_reset();
    t_idle_and_held();
    t_coalesce();
    t_late_event();
    t_ignored_dismiss();
    t_zero();
    t_change_mid();
    t_long();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, irq_o=%0b expected completion", irq_o);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule